// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the two error counters that a CAN node uses for fault confinement and derives the node's confinement state from them. A protocol engine elsewhere detects errors and completed frames and reports each one as a single-cycle pulse. The block then moves a 9-bit transmit counter and an 8-bit receive counter accordingly. It shows the state as error active, error passive or bus-off, and it clears both counters when it receives a bus-off recovery request.

The counters are exposed for read-only register access. The full receive counter and the low byte of the transmit counter are visible. A small diagnosis register sits beside them. It holds the silent-mode and loop-back-mode control bits, which software writes. It also reads back the live level of the receive pin and the bit captured at the last sample point.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, `tecLow` and `recVal` are 0, `errState` is 00, and both diagnosis control bits are 0.
- R2: A `rxErr` pulse adds 1 to the receive counter, or adds 8 when `rxErrSevere` is high in the same cycle. The counter saturates at 255. Counters show the result one clock edge after the event cycle.
- R3: A `rxOk` pulse sets the receive counter to 120 if it is above 128. Otherwise it subtracts 1, and it has no effect when the counter is 0.
- R4: A `txErr` pulse adds 8 to the 9-bit transmit counter. A `txOk` pulse subtracts 1, with no effect at 0. `tecLow` shows bits 7:0 of that counter.
- R5: When an increment and a decrement event for the same counter arrive in one cycle, only the increment is applied.
- R6: `errState` is 10 (bus-off) when the transmit counter exceeds 255. Otherwise it is 01 (error passive) when either counter exceeds 127, and 00 (error active) in all remaining cases. It follows the counters in the same cycle.
- R7: While bus-off, error and success pulses leave both counters unchanged.
- R8: A `recoverReq` pulse clears both counters, so `errState` returns to 00. It overrides any counter event in the same cycle and acts in any state.
- R9: A `diagWe` pulse loads `diagWrData[1]` into the silent-mode bit and `diagWrData[0]` into the loop-back bit. The written values appear on `silentMode`, on `loopbackMode` and in `diagRd[1:0]` after the clock edge.
- R10: `diagRd` bit 3 is the live `rxPin` level, bit 2 is `samplePt`, and bits 7:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxErr | input | 1 | Receive error pulse |
| rxErrSevere | input | 1 | Qualifies rxErr as a severe error (step of 8) |
| rxOk | input | 1 | Successful reception pulse |
| txErr | input | 1 | Transmit error pulse |
| txOk | input | 1 | Successful transmission pulse |
| recoverReq | input | 1 | Bus-off recovery request pulse |
| diagWe | input | 1 | Diagnosis register write strobe |
| diagWrData | input | 2 | Write data: bit 1 silent, bit 0 loop-back |
| rxPin | input | 1 | Live receive pin level |
| samplePt | input | 1 | Bit value at the last sample point |
| tecLow | output | 8 | Transmit error counter, bits 7:0 |
| recVal | output | 8 | Receive error counter |
| errState | output | 2 | 00 active, 01 passive, 10 bus-off |
| diagRd | output | 8 | Diagnosis register read value |
| silentMode | output | 1 | Silent-mode control bit |
| loopbackMode | output | 1 | Loop-back-mode control bit |

## Verification
Bus-off is the hardest state to reach from the ports. It needs more than thirty transmit errors with no success that would pull the counter back. The stimulus first takes the counter into the passive band and out again. It then sends an uninterrupted burst of transmit errors until the counter passes 255, so `tecLow` wraps to a small value while `errState` shows bus-off. The receive reload case likewise needs the counter pushed above 128 through severe errors before a success pulse. A run of severe errors then drives the counter into saturation, and a long run of successes walks it back down to 0.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } errState_e;

  typedef struct packed {
    logic clearAll;
    logic recAddSmall;
    logic recAddLarge;
    logic recReload;
    logic recSub;
    logic tecAdd;
    logic tecSub;
    logic diagWrite;
  } fcStrobe_t;
endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int REC_W         = 8,
  parameter int TEC_W         = 9,
  parameter int RELOAD_ABOVE  = 128,
  parameter int PASSIVE_ABOVE = 127,
  parameter int BUSOFF_ABOVE  = 255
) (
  input  logic             rxErr,
  input  logic             rxErrSevere,
  input  logic             rxOk,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             recoverReq,
  input  logic             diagWe,
  input  logic [REC_W-1:0] recVal,
  input  logic [TEC_W-1:0] tecVal,
  output fcStrobe_t        stb,
  output errState_e        errState
);
  localparam logic [REC_W-1:0] RecReloadThr  = REC_W'(RELOAD_ABOVE);
  localparam logic [REC_W-1:0] RecPassiveThr = REC_W'(PASSIVE_ABOVE);
  localparam logic [TEC_W-1:0] TecPassiveThr = TEC_W'(PASSIVE_ABOVE);
  localparam logic [TEC_W-1:0] TecBusOffThr  = TEC_W'(BUSOFF_ABOVE);

  logic busOff;
  logic passive;
  logic live;

  assign busOff  = tecVal > TecBusOffThr;
  assign passive = (tecVal > TecPassiveThr) || (recVal > RecPassiveThr);
  assign live    = !recoverReq && !busOff;

  always_comb begin
    if (busOff)       errState = ST_BUSOFF;
    else if (passive) errState = ST_PASSIVE;
    else              errState = ST_ACTIVE;
  end

  always_comb begin
    stb             = '0;
    stb.clearAll    = recoverReq;
    stb.diagWrite   = diagWe;
    stb.recAddLarge = live && rxErr && rxErrSevere;
    stb.recAddSmall = live && rxErr && !rxErrSevere;
    stb.recReload   = live && !rxErr && rxOk && (recVal > RecReloadThr);
    stb.recSub      = live && !rxErr && rxOk && (recVal <= RecReloadThr) && (recVal != '0);
    stb.tecAdd      = live && txErr;
    stb.tecSub      = live && !txErr && txOk && (tecVal != '0);
  end
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int REC_W      = 8,
  parameter int TEC_W      = 9,
  parameter int REC_RELOAD = 120,
  parameter int REC_SMALL  = 1,
  parameter int REC_LARGE  = 8,
  parameter int TEC_STEP   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcStrobe_t        stb,
  input  logic [1:0]       diagWrData,
  output logic [REC_W-1:0] recVal,
  output logic [TEC_W-1:0] tecVal,
  output logic             silm,
  output logic             lbkm
);
  localparam logic [REC_W:0]   RecMaxWide = {1'b0, {REC_W{1'b1}}};
  localparam logic [TEC_W:0]   TecMaxWide = {1'b0, {TEC_W{1'b1}}};
  localparam logic [REC_W:0]   RecSmallW  = (REC_W+1)'(REC_SMALL);
  localparam logic [REC_W:0]   RecLargeW  = (REC_W+1)'(REC_LARGE);
  localparam logic [TEC_W:0]   TecStepW   = (TEC_W+1)'(TEC_STEP);
  localparam logic [REC_W-1:0] RecReload  = REC_W'(REC_RELOAD);

  logic [REC_W:0]   recSum;
  logic [TEC_W:0]   tecSum;
  logic [REC_W-1:0] recNext;
  logic [TEC_W-1:0] tecNext;

  assign recSum = {1'b0, recVal} + (stb.recAddLarge ? RecLargeW : RecSmallW);
  assign tecSum = {1'b0, tecVal} + TecStepW;

  always_comb begin
    recNext = recVal;
    if (stb.clearAll)
      recNext = '0;
    else if (stb.recAddLarge || stb.recAddSmall)
      recNext = (recSum > RecMaxWide) ? {REC_W{1'b1}} : recSum[REC_W-1:0];
    else if (stb.recReload)
      recNext = RecReload;
    else if (stb.recSub)
      recNext = recVal - 1'b1;
  end

  always_comb begin
    tecNext = tecVal;
    if (stb.clearAll)
      tecNext = '0;
    else if (stb.tecAdd)
      tecNext = (tecSum > TecMaxWide) ? {TEC_W{1'b1}} : tecSum[TEC_W-1:0];
    else if (stb.tecSub)
      tecNext = tecVal - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recVal <= '0;
      tecVal <= '0;
      silm   <= 1'b0;
      lbkm   <= 1'b0;
    end else begin
      recVal <= recNext;
      tecVal <= tecNext;
      if (stb.diagWrite) begin
        silm <= diagWrData[1];
        lbkm <= diagWrData[0];
      end
    end
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import fc_pkg::*;
#(
  parameter int REC_W = 8,
  parameter int TEC_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxErr,
  input  logic             rxErrSevere,
  input  logic             rxOk,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             recoverReq,
  input  logic             diagWe,
  input  logic [1:0]       diagWrData,
  input  logic             rxPin,
  input  logic             samplePt,
  output logic [7:0]       tecLow,
  output logic [REC_W-1:0] recVal,
  output logic [1:0]       errState,
  output logic [7:0]       diagRd,
  output logic             silentMode,
  output logic             loopbackMode
);
  fcStrobe_t        stb;
  errState_e        stateEnum;
  logic [TEC_W-1:0] tecVal;

  fc_ctrl #(.REC_W(REC_W), .TEC_W(TEC_W)) u_ctrl (
    .rxErr(rxErr), .rxErrSevere(rxErrSevere), .rxOk(rxOk),
    .txErr(txErr), .txOk(txOk), .recoverReq(recoverReq),
    .diagWe(diagWe), .recVal(recVal), .tecVal(tecVal),
    .stb(stb), .errState(stateEnum)
  );

  fc_datapath #(.REC_W(REC_W), .TEC_W(TEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .diagWrData(diagWrData),
    .recVal(recVal), .tecVal(tecVal), .silm(silentMode), .lbkm(loopbackMode)
  );

  assign tecLow   = tecVal[7:0];
  assign errState = stateEnum;
  assign diagRd   = {4'b0000, rxPin, samplePt, silentMode, loopbackMode};
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxErr,
  input logic       rxOk,
  input logic       txErr,
  input logic       recoverReq,
  input logic [7:0] tecLow,
  input logic [7:0] recVal,
  input logic [1:0] errState
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    errState != 2'b11); // R6

  AST_PASSIVE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (errState == 2'b01) |-> (tecLow > 8'd127 || recVal > 8'd127)); // R6

  AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (errState == 2'b10 && !recoverReq) |=> ($stable(tecLow) && $stable(recVal))); // R7

  AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    recoverReq |=> (tecLow == 8'd0 && recVal == 8'd0 && errState == 2'b00)); // R8

  AST_REC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (errState != 2'b10 && !recoverReq && rxOk && !rxErr && recVal > 8'd128)
      |=> (recVal == 8'd120)); // R3

  AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (errState != 2'b10 && !recoverReq && rxErr && recVal == 8'd255)
      |=> (recVal == 8'd255)); // R2

  AST_TEC_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (errState != 2'b10 && !recoverReq && txErr)
      |=> (errState == 2'b10 || tecLow == 8'($past(tecLow) + 8'd8))); // R4
endmodule

bind can_fault_conf fc_checker u_chk (
  .clk(clk), .rstN(rstN), .rxErr(rxErr), .rxOk(rxOk), .txErr(txErr),
  .recoverReq(recoverReq), .tecLow(tecLow), .recVal(recVal), .errState(errState)
);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxErr = 0, rxErrSevere = 0, rxOk = 0, txErr = 0, txOk = 0, recoverReq = 0;
  logic diagWe = 0;
  logic [1:0] diagWrData = 2'b00;
  logic rxPin = 1'b1, samplePt = 1'b0;
  logic [7:0] tecLow, recVal, diagRd;
  logic [1:0] errState;
  logic silentMode, loopbackMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rstN(rstN), .rxErr(rxErr), .rxErrSevere(rxErrSevere), .rxOk(rxOk),
    .txErr(txErr), .txOk(txOk), .recoverReq(recoverReq), .diagWe(diagWe),
    .diagWrData(diagWrData), .rxPin(rxPin), .samplePt(samplePt),
    .tecLow(tecLow), .recVal(recVal), .errState(errState), .diagRd(diagRd),
    .silentMode(silentMode), .loopbackMode(loopbackMode)
  );

  typedef struct {
    logic [7:0] tec;
    logic [7:0] rec;
    logic [1:0] st;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int nTests = 0;
  int nFail  = 0;
  int mTec = 0;
  int mRec = 0;
  bit finished = 0;

  function automatic logic [1:0] modelState();
    if (mTec > 255) return 2'b10;
    if (mTec > 127 || mRec > 127) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of events, updates the model, pushes expectation
  task automatic step(bit re, bit sev, bit ro, bit te, bit to, bit rc, string req);
    expItem_t it;
    @(negedge clk);
    rxErr = re; rxErrSevere = sev; rxOk = ro; txErr = te; txOk = to; recoverReq = rc;
    if (rc) begin
      mTec = 0; mRec = 0;
    end else if (mTec <= 255) begin
      if (re) mRec = (mRec + (sev ? 8 : 1) > 255) ? 255 : mRec + (sev ? 8 : 1);
      else if (ro) mRec = (mRec > 128) ? 120 : ((mRec > 0) ? mRec - 1 : 0);
      if (te) mTec = mTec + 8;
      else if (to && mTec > 0) mTec = mTec - 1;
    end
    it.tec = 8'(mTec); it.rec = 8'(mRec); it.st = modelState(); it.req = req;
    expQ.push_back(it);
    @(posedge clk);
    #1;
    rxErr = 0; rxErrSevere = 0; rxOk = 0; txErr = 0; txOk = 0; recoverReq = 0;
  endtask

  // monitor: compares registered outputs just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nTests++;
        if (tecLow !== it.tec || recVal !== it.rec || errState !== it.st) begin
          nFail++;
          $display("FAIL %s actual tec=%0d rec=%0d st=%b expected tec=%0d rec=%0d st=%b",
                   it.req, tecLow, recVal, errState, it.tec, it.rec, it.st);
        end
      end
    end
  end

  task automatic diagWrite(logic [1:0] d);
    @(negedge clk);
    diagWe = 1; diagWrData = d;
    @(posedge clk);
    #1;
    diagWe = 0; diagWrData = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check8("R1 tecLow", tecLow, 8'd0);
    check8("R1 recVal", recVal, 8'd0);
    check8("R1 errState", {6'd0, errState}, 8'd0);
    check8("R1 diagRd", diagRd, 8'b0000_1000);

    // R2 small and severe receive errors
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R2 small");
    step(1, 1, 0, 0, 0, 0, "R2 severe");
    step(0, 0, 1, 0, 0, 0, "R3 decrement");
    step(1, 0, 1, 0, 0, 0, "R5 rx inc wins");
    // R6 into passive via receive counter
    for (int i = 0; i < 15; i++) step(1, 1, 0, 0, 0, 0, "R6 rec climb");
    step(0, 0, 1, 0, 0, 0, "R3 reload to 120");
    step(1, 1, 0, 0, 0, 0, "R6 rec at 128 passive");
    step(0, 0, 1, 0, 0, 0, "R3 128 decrements to 127");
    // R2 saturation
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, 0, "R2 saturate");
    step(1, 0, 0, 0, 0, 0, "R2 stays 255");
    step(0, 0, 1, 0, 0, 0, "R3 reload from 255");
    for (int i = 0; i < 121; i++) step(0, 0, 1, 0, 0, 0, "R3 walk down");
    step(0, 0, 1, 0, 0, 0, "R3 no effect at 0");

    // R4 transmit counter
    step(0, 0, 0, 0, 1, 0, "R4 txOk at 0");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, "R4 tec climb");
    step(0, 0, 0, 0, 1, 0, "R4 tec decrement");
    step(0, 0, 0, 1, 1, 0, "R5 tx inc wins");
    step(1, 1, 0, 0, 0, 0, "R6 rec while tec passive");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, "R6 toward bus-off");

    // R7 frozen in bus-off
    step(1, 1, 0, 0, 0, 0, "R7 rxErr ignored");
    step(0, 0, 1, 0, 1, 0, "R7 successes ignored");
    step(0, 0, 0, 1, 0, 0, "R7 txErr ignored");

    // R8 recovery overriding events, then from active
    step(1, 1, 0, 1, 0, 1, "R8 recover from bus-off");
    step(1, 1, 0, 1, 0, 0, "R8 counting resumes");
    step(0, 0, 0, 0, 0, 1, "R8 recover from active");

    // R9 and R10 diagnosis register
    diagWrite(2'b11);
    check8("R9 both bits", diagRd, 8'b0000_1011);
    check8("R9 mode outputs", {6'd0, silentMode, loopbackMode}, 8'd3);
    diagWrite(2'b10);
    check8("R9 silent only", {6'd0, silentMode, loopbackMode}, 8'd2);
    @(negedge clk);
    rxPin = 1'b0; samplePt = 1'b1;
    #1;
    check8("R10 pin readback", diagRd, 8'b0000_0110);
    diagWrite(2'b01);
    check8("R10 upper zero, R9 loopback", diagRd, 8'b0000_0101);

    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule